// File: doc/BRIEF.md
# UART Receive Holding FIFO

This block sits between a UART receiver and its register interface and keeps up to four received bytes in arrival order. The receiver offers one byte at a time. The FIFO takes a byte only while the receiver is enabled and the FIFO has room. The oldest stored byte is always visible on the read port, and a read strobe removes it. Two registered status flags report the fill level: one says at least one byte is waiting, the other says all slots are in use.

A detected line break is also stored as a byte. It places a zero byte in the FIFO and latches a delta-break flag, which stays set until it is cleared. A break is stored even when the receiver is disabled. If the FIFO is already full, the zero byte overwrites the newest entry, so the break marker is never lost. A receiver-reset input empties the storage at once.

All state is held in registers, and the reset is synchronous and active high. The stored bytes form a shift chain, so the head byte comes straight from a register.

Top module: `uart_rx_hold_fifo`

## Requirements
- R1: After `rst`, the block shows `rx_ready`=0, `fifo_full`=0, `dbrk`=0 and `rd_data`=0.
- R2: A byte with `push_valid`=1 is stored when `rx_en`=1 and `fifo_full`=0. In the next cycle `rx_ready` is 1.
- R3: `can_accept` equals `rx_en` AND NOT `fifo_full`, in the same cycle.
- R4: `rd_data` always shows the oldest stored byte. A `pop` while `rx_ready`=1 removes that byte, and the next byte appears on `rd_data` one cycle later, in arrival order.
- R5: `fifo_full` is 1 exactly when DEPTH (default 4) bytes are stored. A pop while full clears it in the next cycle.
- R6: `rx_ready` goes to 0 in the cycle after a pop that removes the only stored byte.
- R7: A byte offered while `fifo_full`=1 or `rx_en`=0 is discarded. The stored contents and flags do not change.
- R8: `brk_evt`=1 stores the byte 0x00 whether or not `rx_en` is set, and sets `dbrk` in the next cycle. When `brk_evt` and `push_valid` are high in the same cycle, the break is stored and the data byte is dropped.
- R9: A break that arrives while the FIFO is full, with no pop in the same cycle, replaces the newest stored entry with 0x00. The FIFO stays full and the older entries are unchanged.
- R10: `dbrk_clr`=1 clears `dbrk` in the next cycle. If `brk_evt` is high in the same cycle, the set wins.
- R11: `rx_rst` empties the FIFO and clears `rx_ready` and `fifo_full` in the next cycle. It takes priority over push, break storage and pop, and it leaves `dbrk` unchanged.
- R12: A `pop` while the FIFO is empty has no effect: `rd_data` stays 0 and `rx_ready` stays 0.
- R13: A `pop` and an accepted byte in the same cycle both take effect. The pop is applied first, so a single stored byte is replaced by the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enabled |
| push_valid | input | 1 | Receiver offers a byte |
| push_data | input | W | Offered byte |
| brk_evt | input | 1 | Line break detected (one-cycle pulse) |
| pop | input | 1 | Read strobe on the receive buffer |
| rx_rst | input | 1 | Receiver reset: empty the FIFO |
| dbrk_clr | input | 1 | Clear the delta-break flag |
| rd_data | output | W | Oldest stored byte, 0 when empty |
| rx_ready | output | 1 | At least one byte is stored |
| fifo_full | output | 1 | All DEPTH slots are in use |
| can_accept | output | 1 | A data byte would be taken this cycle |
| dbrk | output | 1 | Delta-break flag |

## Verification
The bench builds the block with its defaults: W=8 and DEPTH=4. A depth of four lets a short directed run fill the FIFO, push against the full state, and land a break on the overwrite path. A random phase then runs for thousands of cycles and hits the fill and drain edges many times. In that phase, breaks, receiver resets and disabled cycles coincide with pops and data bytes, which exercises the priority rules and the rule that the pop is applied first.

// File: rtl/urxf_pkg.sv
package urxf_pkg;
  // Per-cycle operation applied to the storage chain
  typedef struct packed {
    logic clr;    // empty every slot
    logic shift;  // move every slot one step toward the head
    logic wr;     // write one slot after the shift
  } urxf_op_t;
endpackage

// File: rtl/urxf_store.sv
module urxf_store
  import urxf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  urxf_op_t      op,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  head
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] upstream;
    logic [W-1:0] slot_d;
    if (i == DEPTH - 1) begin : g_tail
      assign upstream = '0;
    end else begin : g_mid
      assign upstream = slot_q[i+1];
    end

    always_comb begin
      slot_d = op.shift ? upstream : slot_q[i];
      if (op.wr && (wr_idx == IW'(i))) slot_d = wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst || op.clr) slot_q[i] <= '0;
      else               slot_q[i] <= slot_d;
    end
  end

  assign head = slot_q[0];
endmodule

// File: rtl/urxf_ctrl.sv
module urxf_ctrl
  import urxf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  input  logic          brk_evt,
  input  logic          pop,
  input  logic          rx_rst,
  input  logic          dbrk_clr,
  output urxf_op_t      op,
  output logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic          ready_q,
  output logic          full_q,
  output logic          accept_ok,
  output logic          dbrk_q
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_mid;
  logic [CW-1:0] cnt_d;
  logic          pop_eff;
  logic          take_data;
  logic          brk_over;

  assign accept_ok = rx_en && !full_q;
  assign take_data = push_valid && accept_ok && !brk_evt;
  assign pop_eff   = pop && ready_q;

  always_comb begin
    cnt_mid  = pop_eff ? (cnt_q - CNT_ONE) : cnt_q;
    brk_over = brk_evt && (cnt_mid == CNT_FULL);
    op.clr   = rx_rst;
    op.shift = pop_eff && !rx_rst;
    op.wr    = (brk_evt || take_data) && !rx_rst;
    wr_idx   = brk_over ? IW'(DEPTH - 1) : cnt_mid[IW-1:0];
    wr_data  = brk_evt ? '0 : push_data;
    if (rx_rst)                   cnt_d = '0;
    else if (op.wr && !brk_over)  cnt_d = cnt_mid + CNT_ONE;
    else                          cnt_d = cnt_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      full_q  <= 1'b0;
      dbrk_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= (cnt_d != '0);
      full_q  <= (cnt_d == CNT_FULL);
      if (brk_evt)       dbrk_q <= 1'b1;
      else if (dbrk_clr) dbrk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_hold_fifo.sv
module uart_rx_hold_fifo
  import urxf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_en,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  input  logic         brk_evt,
  input  logic         pop,
  input  logic         rx_rst,
  input  logic         dbrk_clr,
  output logic [W-1:0] rd_data,
  output logic         rx_ready,
  output logic         fifo_full,
  output logic         can_accept,
  output logic         dbrk
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  urxf_op_t      op;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;

  urxf_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
    .push_data(push_data), .brk_evt(brk_evt), .pop(pop), .rx_rst(rx_rst),
    .dbrk_clr(dbrk_clr), .op(op), .wr_idx(wr_idx), .wr_data(wr_data),
    .ready_q(rx_ready), .full_q(fifo_full), .accept_ok(can_accept),
    .dbrk_q(dbrk)
  );

  urxf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .op(op), .wr_idx(wr_idx), .wr_data(wr_data),
    .head(rd_data)
  );
endmodule

// File: rtl/urxf_chk.sv
module urxf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         rx_en,
  input logic         push_valid,
  input logic         brk_evt,
  input logic         pop,
  input logic         rx_rst,
  input logic         dbrk_clr,
  input logic [W-1:0] rd_data,
  input logic         rx_ready,
  input logic         fifo_full,
  input logic         can_accept,
  input logic         dbrk
);
  AST_ACCEPT_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    (push_valid && can_accept && !rx_rst) |=> rx_ready); // R2
  AST_FULL_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !can_accept); // R3
  AST_FULL_HAS_READY: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rx_ready); // R5
  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> dbrk); // R8
  AST_BREAK_STORES: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && !rx_rst) |=> rx_ready); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dbrk_clr && !brk_evt) |=> !dbrk); // R10
  AST_RXRST_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> (!rx_ready && !fifo_full && rd_data == '0)); // R11
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pop && !rx_ready && !brk_evt && !(push_valid && can_accept))
      |=> (!rx_ready && rd_data == '0)); // R12
endmodule

bind uart_rx_hold_fifo urxf_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
  .brk_evt(brk_evt), .pop(pop), .rx_rst(rx_rst), .dbrk_clr(dbrk_clr),
  .rd_data(rd_data), .rx_ready(rx_ready), .fifo_full(fifo_full),
  .can_accept(can_accept), .dbrk(dbrk)
);

// File: tb/uart_rx_hold_fifo_bench.sv
module uart_rx_hold_fifo_bench;
  localparam int PER   = 10;
  localparam int W     = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0, pop = 1'b0;
  logic rx_rst = 1'b0, dbrk_clr = 1'b0;
  logic [W-1:0] push_data = '0;
  logic [W-1:0] rd_data;
  logic rx_ready, fifo_full, can_accept, dbrk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0] m_q [DEPTH];
  int  m_cnt = 0;
  bit  m_dbrk = 1'b0;

  always #(PER/2) clk = ~clk;

  uart_rx_hold_fifo #(.W(W), .DEPTH(DEPTH)) u_uart_rx_hold_fifo (
    .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
    .push_data(push_data), .brk_evt(brk_evt), .pop(pop), .rx_rst(rx_rst),
    .dbrk_clr(dbrk_clr), .rd_data(rd_data), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .can_accept(can_accept), .dbrk(dbrk)
  );

  function automatic logic [W-1:0] m_head();
    return (m_cnt > 0) ? m_q[0] : '0;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit pv, logic [W-1:0] pd, bit bk, bit pp,
                            bit en, bit rr, bit dc, bit rs);
    bit was_full;
    if (rs) begin
      m_cnt = 0; m_dbrk = 0;
      for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
      return;
    end
    if (bk) m_dbrk = 1;
    else if (dc) m_dbrk = 0;
    if (rr) begin
      m_cnt = 0;
      for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
      return;
    end
    was_full = (m_cnt == DEPTH);
    if (pp && m_cnt > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
      m_q[DEPTH-1] = '0;
      m_cnt--;
    end
    if (bk) begin
      if (m_cnt == DEPTH) m_q[DEPTH-1] = '0;
      else begin m_q[m_cnt] = '0; m_cnt++; end
    end else if (pv && en && !was_full) begin
      m_q[m_cnt] = pd; m_cnt++;
    end
  endtask

  // one cycle: drive at negedge, clock, compare at the following negedge
  task automatic step(bit pv, logic [W-1:0] pd, bit bk, bit pp,
                      bit en, bit rr, bit dc, bit rs);
    push_valid = pv; push_data = pd; brk_evt = bk; pop = pp;
    rx_en = en; rx_rst = rr; dbrk_clr = dc; rst = rs;
    model_step(pv, pd, bk, pp, en, rr, dc, rs);
    @(posedge clk);
    @(negedge clk);
    check("R4 rd_data", rd_data, m_head());
    check("R6 rx_ready", {7'b0, rx_ready}, {7'b0, m_cnt > 0});
    check("R5 fifo_full", {7'b0, fifo_full}, {7'b0, m_cnt == DEPTH});
    check("R3 can_accept", {7'b0, can_accept}, {7'b0, en && (m_cnt != DEPTH)});
    check("R8 dbrk", {7'b0, dbrk}, {7'b0, m_dbrk});
  endtask

  task automatic push(logic [W-1:0] d);
    step(1, d, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic rd();
    step(0, 0, 0, 1, 1, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 flags", {5'b0, rx_ready, fifo_full, dbrk}, 8'h00);

    push(8'hA1);
    check("R2 ready after push", {7'b0, rx_ready}, 8'h01);
    push(8'hA2); push(8'hA3); push(8'hA4);
    check("R5 full at depth", {7'b0, fifo_full}, 8'h01);
    check("R3 no accept when full", {7'b0, can_accept}, 8'h00);
    push(8'h55);
    check("R7 full drop keeps head", rd_data, 8'hA1);
    rd();
    check("R4 order 2nd", rd_data, 8'hA2);
    check("R5 full cleared by pop", {7'b0, fifo_full}, 8'h00);
    rd(); check("R4 order 3rd", rd_data, 8'hA3);
    rd(); check("R7 dropped byte absent", rd_data, 8'hA4);
    rd();
    check("R6 empty after last pop", {7'b0, rx_ready}, 8'h00);
    rd();
    check("R12 empty pop data", rd_data, 8'h00);
    check("R12 empty pop ready", {7'b0, rx_ready}, 8'h00);

    step(1, 8'h66, 0, 0, 0, 0, 0, 0);
    check("R7 disabled drop", {7'b0, rx_ready}, 8'h00);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R8 break stored while disabled", {7'b0, rx_ready}, 8'h01);
    check("R8 break byte zero", rd_data, 8'h00);
    check("R8 flag set", {7'b0, dbrk}, 8'h01);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    check("R10 flag cleared", {7'b0, dbrk}, 8'h00);
    step(0, 0, 1, 0, 1, 0, 1, 0);
    check("R10 set wins", {7'b0, dbrk}, 8'h01);
    step(0, 0, 0, 0, 1, 1, 0, 0);
    check("R11 emptied", {6'b0, rx_ready, fifo_full}, 8'h00);
    check("R11 flag kept", {7'b0, dbrk}, 8'h01);

    push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    check("R9 still full", {7'b0, fifo_full}, 8'h01);
    rd(); rd(); rd();
    check("R9 newest replaced", rd_data, 8'h00);
    rd();
    step(0, 0, 0, 0, 1, 1, 0, 0);

    push(8'hC1);
    step(1, 8'hC2, 0, 1, 1, 0, 0, 0);
    check("R13 pop and push", rd_data, 8'hC2);
    check("R13 one entry", {7'b0, rx_ready}, 8'h01);
    step(1, 8'h77, 1, 0, 1, 0, 0, 0);
    rd();
    check("R8 break beats data", rd_data, 8'h00);
    rd();
    check("R8 data dropped", {7'b0, rx_ready}, 8'h00);

    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      step($urandom_range(0, 1) == 1, W'($urandom()),
           $urandom_range(0, 19) == 0, $urandom_range(0, 9) < 4,
           $urandom_range(0, 19) != 0, $urandom_range(0, 49) == 0,
           $urandom_range(0, 19) == 0, 1'b0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule